// File: doc/BRIEF.md
# Byte-Wide RAM with Double-Buffered Clock Registers

This block is a 2K x 8 byte-wide memory port, modelled on a single system clock, whose top eight addresses are clock registers rather than storage. Software reads and writes those registers with the same strobes it uses for ordinary bytes. Each clock register is an external copy that software sees, and it is backed by an internal timekeeping counter that keeps running while software works on the copies.

The control byte holds two freeze bits and the BCD century. The read-freeze bit holds the visible copies steady so that a multi-byte time can be read consistently. The set-freeze bit lets software load new time values, which move into the counters when the bit is cleared. The seconds byte also carries an oscillator-stop bit, and the day byte carries a frequency-test bit and a read-only battery-status bit. A 512 Hz tick input drives the sub-second prescaler and sets the timing resolution of the copy refresh.

The counter advances only the seconds field, 00 to 59 in BCD. Minute and larger carries belong to a separate calendar unit. The other time fields hold whatever value was last loaded into them.

Top module: `rtc_ram_regfile`

## Requirements
- R1: A read is requested when ce_n=0, oe_n=0 and we_n=1. rd_valid and rdata reflect that request one clock later. Otherwise rd_valid=0 and rdata=0. A write happens when ce_n=0 and we_n=0. After reset every clock register reads 0x00, except that the day byte reads bit 7 equal to batt_ok.
- R2: Every address below 0x7F8 is a plain byte. It returns the last value written to it.
- R3: The clock window is laid out as follows: 0x7F8 control, 0x7F9 seconds, 0x7FA minutes, 0x7FB hours, 0x7FC day, 0x7FD date, 0x7FE month, 0x7FF year. In the control byte, bit 7 is set-freeze, bit 6 is read-freeze and bits 5:0 are the century. All 8 control bits read back as written.
- R4: While read-freeze is 1, the visible time fields keep their values even though the internal seconds count goes on.
- R5: After read-freeze (and set-freeze) are both 0, the first tick only arms the refresh. Every later tick copies all internal fields to the visible copies in the same cycle. The new time is therefore visible after the second tick and not after the first.
- R6: Time-field bits can be written only while set-freeze is 1. These are seconds 6:0, minutes 6:0, hours 5:0, day 2:0, date 5:0, month 4:0 and year 7:0. With set-freeze 0, writes to them leave the readback unchanged.
- R7: A control write that clears set-freeze copies the visible time fields into the internal counters and restarts the sub-second prescaler. This happens even if read-freeze stays 1.
- R8: When running, the internal seconds advance by one on every 512th tick in BCD, and 59 is followed by 00.
- R9: Seconds bit 7 set to 1 stops the prescaler and the seconds count. Clearing it resumes counting from the held prescaler position.
- R10: When day bit 6 is 1 and the oscillator runs, seconds bit 0 on a read shows a phase that inverts on every tick. The other seconds bits are unaffected.
- R11: Day bit 7 always reads as batt_ok. Writes to that bit are ignored.
- R12: The bits of minutes 7, hours 7:6, day 5:3, date 7:6 and month 7:5 serve no clock function. They are plain read/write bits at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| tick_512 | input | 1 | One-clock pulse at 512 Hz |
| batt_ok | input | 1 | Battery status, 1 = good |
| rdata | output | 8 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid (drive enable) |

## Verification
The assertions assume the following about the inputs:
- tick_512 is a one-clock pulse spaced well apart from other pulses.
- The only way internal counters get loaded is through a control-byte write.
- Strobes are clean levels sampled at the clock edge.

The bench meets these assumptions as follows:
- It drives every input on the falling edge.
- Each tick is a single-cycle pulse followed by idle cycles.
- Accesses are one-cycle strobes.
- It loads only valid BCD time values, so the seconds counter never sees a non-BCD digit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_SEC   = 3'd1;
    localparam logic [2:0] IDX_MIN   = 3'd2;
    localparam logic [2:0] IDX_HOUR  = 3'd3;
    localparam logic [2:0] IDX_DAY   = 3'd4;
    localparam logic [2:0] IDX_DATE  = 3'd5;
    localparam logic [2:0] IDX_MONTH = 3'd6;
    localparam logic [2:0] IDX_YEAR  = 3'd7;

    // Architectural state of the clock window
    typedef struct packed {
        logic [7:0][7:0] ext;     // visible copies, [0] is the control byte
        logic [7:1][7:0] tm;      // internal counters (time bits only)
        logic            armed;   // refresh armed after release
        logic            rd_valid;
        logic            sel_clk;
        logic [7:0]      rd_clk;
    } rtc_state_t;

    // Bits of each register that belong to the time value
    function automatic logic [7:0] time_mask(input logic [2:0] idx);
        case (idx)
            IDX_SEC:   return 8'h7F;
            IDX_MIN:   return 8'h7F;
            IDX_HOUR:  return 8'h3F;
            IDX_DAY:   return 8'h07;
            IDX_DATE:  return 8'h3F;
            IDX_MONTH: return 8'h1F;
            IDX_YEAR:  return 8'hFF;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic logic [6:0] bcd_sec_next(input logic [6:0] s);
        if (s[3:0] == 4'd9)
            return (s[6:4] == 3'd5) ? 7'h00 : {s[6:4] + 3'd1, 4'h0};
        return {s[6:4], s[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) q <= mem[addr];
    end
endmodule

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
    parameter int TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic clr,
    output logic sec_pulse,
    output logic phase
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick && run) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            st_d.ph  = ~st_q.ph;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_pulse = tick && run && !clr && (st_q.cnt == LAST);
    assign phase     = st_q.ph;
endmodule

// File: rtl/rtc_ram_regfile.sv
module rtc_ram_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W        = 11,
    parameter int TICKS_PER_SEC = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              tick_512,
    input  logic              batt_ok,
    output logic [7:0]        rdata,
    output logic              rd_valid
);
    localparam int WIN_W = ADDR_W - 3;

    rtc_state_t st_d, st_q;

    logic       rd_req, wr_req, in_clk, wr_clk, xfer, halt_q;
    logic [2:0] idx;
    logic       sec_pulse, phase;
    logic [7:0] ram_q;

    // Observation points for the bound checker
    logic        w_bit, r_bit, osc_stop;
    logic [55:0] ext_time_flat, int_time_flat;
    logic [6:0]  int_sec;

    assign rd_req = !ce_n && !oe_n && we_n;
    assign wr_req = !ce_n && !we_n;
    assign in_clk = (addr[ADDR_W-1:3] == {WIN_W{1'b1}});
    assign idx    = addr[2:0];
    assign wr_clk = wr_req && in_clk;
    assign halt_q = st_q.ext[IDX_CTRL][7] | st_q.ext[IDX_CTRL][6];
    assign xfer   = wr_clk && (idx == IDX_CTRL) && st_q.ext[IDX_CTRL][7] && !wdata[7];

    rtc_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk   (clk),
        .we    (wr_req && !in_clk),
        .re    (rd_req),
        .addr  (addr),
        .wdata (wdata),
        .q     (ram_q)
    );

    rtc_subsec_div #(.TICKS(TICKS_PER_SEC)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_512),
        .run       (!st_q.ext[IDX_SEC][7]),
        .clr       (xfer),
        .sec_pulse (sec_pulse),
        .phase     (phase)
    );

    always_comb begin
        logic [7:0] m;
        logic [7:0] keep;
        logic [7:0] nv;
        logic [7:0] rb;

        st_d = st_q;

        // Software writes into the clock window
        m    = time_mask(idx);
        keep = st_q.ext[IDX_CTRL][7] ? 8'h00 : m;
        nv   = (wdata & ~keep) | (st_q.ext[idx] & keep);
        if (idx == IDX_DAY) nv[7] = 1'b0;
        if (wr_clk) begin
            if (idx == IDX_CTRL) st_d.ext[IDX_CTRL] = wdata;
            else                 st_d.ext[idx]      = nv;
        end

        // Internal counters: load on set release, else count seconds
        if (xfer) begin
            for (int i = 1; i < 8; i++)
                st_d.tm[i] = st_q.ext[i] & time_mask(3'(i));
        end else if (sec_pulse) begin
            st_d.tm[IDX_SEC][6:0] = bcd_sec_next(st_q.tm[IDX_SEC][6:0]);
        end

        // Visible copy refresh, armed by one tick after release
        if (halt_q) begin
            st_d.armed = 1'b0;
        end else if (tick_512) begin
            if (st_q.armed) begin
                for (int i = 1; i < 8; i++)
                    st_d.ext[i] = (st_d.ext[i] & ~time_mask(3'(i)))
                                | (st_d.tm[i] & time_mask(3'(i)));
            end
            st_d.armed = 1'b1;
        end

        // Read path of the clock window
        rb = st_q.ext[idx];
        if (idx == IDX_DAY) rb[7] = batt_ok;
        if (idx == IDX_SEC && st_q.ext[IDX_DAY][6] && !st_q.ext[IDX_SEC][7])
            rb[0] = phase;
        st_d.rd_valid = rd_req;
        st_d.sel_clk  = in_clk;
        st_d.rd_clk   = (rd_req && in_clk) ? rb : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rdata    = !st_q.rd_valid ? 8'h00 : (st_q.sel_clk ? st_q.rd_clk : ram_q);

    assign w_bit    = st_q.ext[IDX_CTRL][7];
    assign r_bit    = st_q.ext[IDX_CTRL][6];
    assign osc_stop = st_q.ext[IDX_SEC][7];
    assign int_sec  = st_q.tm[IDX_SEC][6:0];

    for (genvar g = 1; g < 8; g++) begin : g_flat
        assign ext_time_flat[(g-1)*8 +: 8] = st_q.ext[g] & time_mask(3'(g));
        assign int_time_flat[(g-1)*8 +: 8] = st_q.tm[g];
    end
endmodule

// File: rtl/rtc_regfile_checker.sv
module rtc_regfile_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              tick_512,
    input logic              batt_ok,
    input logic [7:0]        rdata,
    input logic              rd_valid,
    input logic              w_bit,
    input logic              r_bit,
    input logic              osc_stop,
    input logic [55:0]       ext_time_flat,
    input logic [55:0]       int_time_flat,
    input logic [6:0]        int_sec
);
    logic win, rd_cond, wr_cond, ctrl_wr, day_rd, time_wr;

    assign win     = (addr[ADDR_W-1:3] == {(ADDR_W-3){1'b1}});
    assign rd_cond = !ce_n && !oe_n && we_n;
    assign wr_cond = !ce_n && !we_n;
    assign ctrl_wr = wr_cond && win && (addr[2:0] == 3'd0);
    assign day_rd  = rd_cond && win && (addr[2:0] == 3'd4);
    assign time_wr = wr_cond && win && (addr[2:0] != 3'd0);

    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cond |=> rd_valid);

    p_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cond |=> (!rd_valid && rdata == 8'h00));

    p_freeze_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_bit && !wr_cond) |=> $stable(ext_time_flat));

    p_time_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_bit && time_wr && !tick_512) |=> $stable(ext_time_flat));

    p_set_transfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(w_bit) |-> (int_time_flat == $past(ext_time_flat)));

    p_osc_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !ctrl_wr) |=> $stable(int_sec));

    p_batt_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        day_rd |=> (rdata[7] == $past(batt_ok)));
endmodule

bind rtc_ram_regfile rtc_regfile_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .we_n          (we_n),
    .addr          (addr),
    .tick_512      (tick_512),
    .batt_ok       (batt_ok),
    .rdata         (rdata),
    .rd_valid      (rd_valid),
    .w_bit         (w_bit),
    .r_bit         (r_bit),
    .osc_stop      (osc_stop),
    .ext_time_flat (ext_time_flat),
    .int_time_flat (int_time_flat),
    .int_sec       (int_sec)
);

// File: tb/rtc_ram_regfile_tb.sv
module rtc_ram_regfile_tb;
    localparam logic [10:0] A_CTRL  = 11'h7F8;
    localparam logic [10:0] A_SEC   = 11'h7F9;
    localparam logic [10:0] A_MIN   = 11'h7FA;
    localparam logic [10:0] A_HOUR  = 11'h7FB;
    localparam logic [10:0] A_DAY   = 11'h7FC;
    localparam logic [10:0] A_DATE  = 11'h7FD;
    localparam logic [10:0] A_MONTH = 11'h7FE;
    localparam logic [10:0] A_YEAR  = 11'h7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        tick_512 = 1'b0;
    logic        batt_ok = 1'b1;
    logic [7:0]  rdata;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_ram_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .tick_512(tick_512), .batt_ok(batt_ok),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_512 = 1'b1;
            @(negedge clk); tick_512 = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic expect_rd(input string req, input string what,
                             input logic [10:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, what, d, exp);
    endtask

    task automatic t_reset;
        check("R1", "rd_valid idle after reset", {7'b0, rd_valid}, 8'h00);
        expect_rd("R1", "control after reset", A_CTRL, 8'h00);
        expect_rd("R1", "seconds after reset", A_SEC, 8'h00);
        expect_rd("R1", "day after reset", A_DAY, 8'h80);
    endtask

    task automatic t_decode;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 11'h010;
        @(negedge clk);
        check("R1", "rd_valid on read", {7'b0, rd_valid}, 8'h01);
        oe_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_valid with oe high", {7'b0, rd_valid}, 8'h00);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; wdata = 8'h77;
        @(negedge clk);
        check("R1", "rd_valid during write", {7'b0, rd_valid}, 8'h00);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check("R1", "rdata zero when idle", rdata, 8'h00);
        expect_rd("R1", "write with oe low stored", 11'h010, 8'h77);
    endtask

    task automatic t_ram;
        wr(11'h000, 8'hA5);
        wr(11'h7F7, 8'h3C);
        wr(11'h400, 8'h5A);
        expect_rd("R2", "ram 0x000", 11'h000, 8'hA5);
        expect_rd("R2", "ram 0x400", 11'h400, 8'h5A);
        expect_rd("R2", "ram 0x7F7", 11'h7F7, 8'h3C);
    endtask

    task automatic t_set_and_count;
        wr(A_CTRL, 8'hA0);
        expect_rd("R3", "control with set bit", A_CTRL, 8'hA0);
        wr(A_SEC, 8'h58);  wr(A_MIN, 8'h59);  wr(A_HOUR, 8'h23);
        wr(A_DAY, 8'h05);  wr(A_DATE, 8'h31); wr(A_MONTH, 8'h12);
        wr(A_YEAR, 8'h99);
        expect_rd("R3", "seconds loaded", A_SEC, 8'h58);
        expect_rd("R3", "minutes loaded", A_MIN, 8'h59);
        expect_rd("R3", "hours loaded", A_HOUR, 8'h23);
        expect_rd("R3", "day loaded", A_DAY, 8'h85);
        expect_rd("R3", "date loaded", A_DATE, 8'h31);
        expect_rd("R3", "month loaded", A_MONTH, 8'h12);
        expect_rd("R3", "year loaded", A_YEAR, 8'h99);
        wr(A_CTRL, 8'h20);
        ticks(512);
        expect_rd("R7", "seconds one second after load", A_SEC, 8'h59);
        ticks(512);
        expect_rd("R8", "seconds wrap 59 to 00", A_SEC, 8'h00);
        expect_rd("R8", "minutes held", A_MIN, 8'h59);
        expect_rd("R2", "ram untouched by clock writes", 11'h7F7, 8'h3C);
    endtask

    task automatic t_write_ignored;
        wr(A_SEC, 8'h33);
        expect_rd("R6", "seconds write ignored", A_SEC, 8'h00);
        wr(A_MIN, 8'h91);
        expect_rd("R12", "minutes spare bit kept", A_MIN, 8'hD9);
        wr(A_MIN, 8'h00);
        expect_rd("R12", "minutes spare bit cleared", A_MIN, 8'h59);
        wr(A_HOUR, 8'hC0);
        expect_rd("R12", "hours spare bits", A_HOUR, 8'hE3);
        wr(A_YEAR, 8'h01);
        expect_rd("R6", "year write ignored", A_YEAR, 8'h99);
    endtask

    task automatic t_read_halt;
        wr(A_CTRL, 8'h60);
        ticks(512);
        expect_rd("R4", "seconds frozen", A_SEC, 8'h00);
        wr(A_CTRL, 8'h20);
        expect_rd("R5", "no refresh at release", A_SEC, 8'h00);
        ticks(1);
        expect_rd("R5", "no refresh after one tick", A_SEC, 8'h00);
        ticks(1);
        expect_rd("R5", "refresh after second tick", A_SEC, 8'h01);
    endtask

    task automatic t_osc_stop;
        wr(A_SEC, 8'h80);
        expect_rd("R9", "stop bit stored", A_SEC, 8'h81);
        ticks(600);
        expect_rd("R9", "seconds held while stopped", A_SEC, 8'h81);
        wr(A_SEC, 8'h00);
        ticks(509);
        expect_rd("R8", "one tick before second", A_SEC, 8'h01);
        ticks(1);
        expect_rd("R8", "second boundary", A_SEC, 8'h02);
    endtask

    task automatic t_freq_test;
        logic [7:0] a, b, c;
        wr(A_DAY, 8'h45);
        expect_rd("R10", "test bit stored", A_DAY, 8'hC5);
        rd(A_SEC, a);
        ticks(1);
        rd(A_SEC, b);
        ticks(1);
        rd(A_SEC, c);
        check("R10", "bit0 inverts on tick", {7'b0, a[0] ^ b[0]}, 8'h01);
        check("R10", "bit0 inverts again", {7'b0, b[0] ^ c[0]}, 8'h01);
        check("R10", "upper seconds bits", {1'b0, b[7:1]}, 8'h01);
        wr(A_DAY, 8'h05);
        expect_rd("R10", "seconds plain with test off", A_SEC, 8'h02);
    endtask

    task automatic t_batt_flag;
        @(negedge clk); batt_ok = 1'b0;
        expect_rd("R11", "flag low", A_DAY, 8'h05);
        wr(A_DAY, 8'h85);
        expect_rd("R11", "flag write ignored", A_DAY, 8'h05);
        @(negedge clk); batt_ok = 1'b1;
        expect_rd("R11", "flag high", A_DAY, 8'h85);
    endtask

    task automatic t_priority;
        wr(A_CTRL, 8'hE0);
        expect_rd("R3", "both freeze bits", A_CTRL, 8'hE0);
        wr(A_SEC, 8'h10);
        wr(A_CTRL, 8'h60);
        ticks(2);
        wr(A_CTRL, 8'h20);
        ticks(2);
        expect_rd("R7", "load with read freeze held", A_SEC, 8'h10);
        expect_rd("R3", "control after release", A_CTRL, 8'h20);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_decode;
        t_ram;
        t_set_and_count;
        t_write_ignored;
        t_read_halt;
        t_osc_stop;
        t_freq_test;
        t_batt_flag;
        t_priority;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule